// File: doc/BRIEF.md
# Extended-Format Instruction Address Generator

This block sits between instruction fetch and operand access in a 24-bit processor with a 1 MB address space. Each cycle that `start` is high, it takes the first four bytes of an instruction, the address of that instruction and the current base and index register values. From these it works out four things: the instruction length, the six addressing flag bits, the target address and the operand kind. The operand kind is no operand, an immediate value, a simple memory operand, or an operand reached through a pointer. The results are registered and become valid with a one-cycle `done` pulse.

When an instruction asks for indirection, the block does not report the result at once. It first raises `ind_req` with the pointer address and holds that request until the datapath returns the fetched word on `ind_ack`/`ind_data`. It then reports the pointer's low 20 bits as the final operand address. Instructions with an illegal flag combination are still reported with `done`, but with `illegal` set, and they never start an indirection read.

Top module: `xe_addr_gen`

## Requirements
- R1: The instruction length follows the opcode byte (bits 31:24 of `instr`). A high nibble of C or F gives length 1, and a high nibble of 9, A or B gives length 2; both report kind 0 (none), flags 0 and target 0. Every other opcode gives length 4 when the e flag (bit 20) is 1 and n or i is set, and length 3 otherwise.
- R2: When n (bit 25) and i (bit 24) are both 0, the instruction uses the older layout: length 3, x taken from bit 23, target = bits 22:8 (15-bit address) plus X when x is set, kind 2 (memory), flags {0,0,x,0,0,0}. The flags output is packed as {n,i,x,b,p,e}, with n in bit 5.
- R3: In the 3-byte form with b=1 (bit 22) and p=0 (bit 21), the target is B plus the unsigned 12-bit displacement (bits 19:8), modulo 2^20.
- R4: In the 3-byte form with b=0 and p=1, the target is the instruction address plus 3 plus the sign-extended 12-bit displacement, modulo 2^20.
- R5: With b=0 and p=0, the target is the zero-extended 12-bit displacement (3-byte form) or the 20-bit field in bits 19:0 (4-byte form). The 4-byte form ignores b and p when forming the target.
- R6: When x (bit 23) is set, the low 20 bits of X are added into the target, modulo 2^20.
- R7: n=0, i=1 reports kind 1 (immediate), with the computed value as the target and no indirection request. n=1, i=1 reports kind 2 (memory).
- R8: n=1, i=0 on a legal instruction raises `ind_req` in the cycle after `start`, with `ind_addr` set to the computed target. The request and address are held until `ind_ack`. In the cycle after `ind_ack`, `done` pulses, `ind_req` falls, kind is 3 and the target is the low 20 bits of `ind_data`.
- R9: `illegal` is set, and no indirection is requested, for any of these: x=1 with immediate or indirect mode; b=1 and p=1 together (target then formed as if b=p=0); b or p set in the 4-byte form. `done` still pulses the cycle after `start`.
- R10: While an indirection request is pending, `start` is ignored: the length, flags and pending address stay unchanged.
- R11: After reset `done`, `ind_req`, `illegal` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction bytes and registers are valid this cycle |
| instr | input | 32 | First four instruction bytes, first byte in bits 31:24 |
| pc | input | 20 | Address of the instruction being decoded |
| base_reg | input | 24 | Base register value |
| index_reg | input | 24 | Index register value |
| ind_ack | input | 1 | Pointer word is present on ind_data |
| ind_data | input | 24 | Pointer word fetched from ind_addr |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| len | output | 3 | Instruction length in bytes |
| flags | output | 6 | Addressing flags {n,i,x,b,p,e} |
| kind | output | 2 | 0 none, 1 immediate, 2 memory, 3 resolved indirect |
| ta | output | 20 | Target address or immediate value |
| illegal | output | 1 | Illegal flag combination |
| ind_req | output | 1 | Indirection read requested |
| ind_addr | output | 20 | Address of the pointer word |

## Verification
The hardest state to reach is a pending indirection that keeps seeing new instructions. The stimulus launches a legal indirect instruction and holds the acknowledge low for several cycles. During that wait it keeps `start` high with a different instruction, so the bench can confirm that the request, the pending address and the reported flags do not move. Address wrap is forced by setting the base and index registers near the top of the 1 MB space. A PC-relative case with the most negative displacement tests the sign extension.

// File: rtl/xe_ag_pkg.sv
package xe_ag_pkg;

   typedef enum logic [1:0] {
      OPK_NONE = 2'd0,
      OPK_IMM  = 2'd1,
      OPK_MEM  = 2'd2,
      OPK_IND  = 2'd3
   } opkind_e;

   typedef enum logic [1:0] {
      BSEL_ZERO = 2'd0,
      BSEL_BASE = 2'd1,
      BSEL_PC   = 2'd2
   } bsel_e;

   localparam int INSTR_W = 32;
   localparam int DISP_W  = 12;
   localparam int LONG_W  = 20;
   localparam int OLD_W   = 15;
   localparam int LEN_W   = 3;
   localparam int FLAG_W  = 6;

   function automatic logic op_is_one_byte(input logic [7:0] op);
      return (op[7:4] == 4'hC) || (op[7:4] == 4'hF);
   endfunction

   function automatic logic op_is_two_byte(input logic [7:0] op);
      return (op[7:4] == 4'h9) || (op[7:4] == 4'hA) || (op[7:4] == 4'hB);
   endfunction

endpackage

// File: rtl/xe_ag_decode.sv
module xe_ag_decode
   import xe_ag_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output logic [LEN_W-1:0]   len_o,
   output logic [FLAG_W-1:0]  flags_o,
   output opkind_e            kind_o,
   output logic               illegal_o,
   output logic               short_o,
   output bsel_e              bsel_o,
   output logic [LONG_W-1:0]  off_o,
   output logic               off_neg_o,
   output logic               use_idx_o
);

   logic [7:0] op_byte, b1, b2, b3;
   logic       fn, fi, fx, fb, fp, fe;
   logic       one_b, two_b, old_form, long_form;
   logic [DISP_W-1:0] disp;

   assign op_byte = instr[31:24];
   assign b1      = instr[23:16];
   assign b2      = instr[15:8];
   assign b3      = instr[7:0];

   assign fn = op_byte[1];
   assign fi = op_byte[0];
   assign fx = b1[7];
   assign fb = b1[6];
   assign fp = b1[5];
   assign fe = b1[4];

   assign one_b     = op_is_one_byte(op_byte);
   assign two_b     = op_is_two_byte(op_byte);
   assign old_form  = !one_b && !two_b && !fn && !fi;
   assign long_form = !one_b && !two_b && !old_form && fe;
   assign disp      = {b1[3:0], b2};

   always_comb begin
      len_o     = 3'd3;
      flags_o   = '0;
      kind_o    = OPK_MEM;
      illegal_o = 1'b0;
      short_o   = 1'b0;
      bsel_o    = BSEL_ZERO;
      off_o     = '0;
      off_neg_o = 1'b0;
      use_idx_o = 1'b0;
      if (one_b || two_b) begin
         len_o   = one_b ? 3'd1 : 3'd2;
         kind_o  = OPK_NONE;
         short_o = 1'b1;
      end else if (old_form) begin
         flags_o   = {1'b0, 1'b0, fx, 3'b000};
         off_o     = {{(LONG_W-OLD_W){1'b0}}, b1[6:0], b2};
         use_idx_o = fx;
      end else begin
         flags_o   = {fn, fi, fx, fb, fp, fe};
         use_idx_o = fx;
         case ({fn, fi})
            2'b01:   kind_o = OPK_IMM;
            2'b10:   kind_o = OPK_IND;
            default: kind_o = OPK_MEM;
         endcase
         if (fx && (fn != fi))
            illegal_o = 1'b1;
         if (long_form) begin
            len_o = 3'd4;
            off_o = {b1[3:0], b2, b3};
            if (fb || fp)
               illegal_o = 1'b1;
         end else begin
            off_o = {{(LONG_W-DISP_W){1'b0}}, disp};
            if (fb && fp) begin
               illegal_o = 1'b1;
            end else if (fb) begin
               bsel_o = BSEL_BASE;
            end else if (fp) begin
               bsel_o    = BSEL_PC;
               off_o     = {{(LONG_W-DISP_W){disp[DISP_W-1]}}, disp};
               off_neg_o = disp[DISP_W-1];
            end
         end
      end
   end

endmodule

// File: rtl/xe_ag_calc.sv
module xe_ag_calc
   import xe_ag_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] breg,
   input  logic [ADDR_W-1:0] xreg,
   input  logic [LEN_W-1:0]  len,
   input  bsel_e             bsel,
   input  logic [LONG_W-1:0] off,
   input  logic              off_neg,
   input  logic              use_idx,
   input  logic              short_in,
   output logic [ADDR_W-1:0] ta_o
);

   localparam int EXT_W = ADDR_W - LONG_W;

   logic [ADDR_W-1:0] off_ext, base_val, idx_val, pc_next;

   generate
      if (EXT_W > 0) begin : g_ext
         assign off_ext = {{EXT_W{off_neg}}, off};
      end else begin : g_noext
         assign off_ext = off[ADDR_W-1:0];
      end
   endgenerate

   assign pc_next = pc + {{(ADDR_W-LEN_W){1'b0}}, len};

   always_comb begin
      case (bsel)
         BSEL_BASE: base_val = breg;
         BSEL_PC:   base_val = pc_next;
         default:   base_val = '0;
      endcase
   end

   assign idx_val = use_idx ? xreg : '0;
   assign ta_o    = short_in ? '0 : (base_val + off_ext + idx_val);

endmodule

// File: rtl/xe_ag_ctl.sv
module xe_ag_ctl
   import xe_ag_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int WORD_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   len_in,
   input  logic [FLAG_W-1:0]  flags_in,
   input  opkind_e            kind_in,
   input  logic               illegal_in,
   input  logic [ADDR_W-1:0]  ta_in,
   input  logic               ind_ack,
   input  logic [WORD_W-1:0]  ind_data,
   output logic               done,
   output logic [LEN_W-1:0]   len_q,
   output logic [FLAG_W-1:0]  flags_q,
   output opkind_e            kind_q,
   output logic               illegal_q,
   output logic [ADDR_W-1:0]  ta_q,
   output logic               ind_req,
   output logic [ADDR_W-1:0]  ind_addr
);

   logic [ADDR_W-1:0] ptr;

   generate
      if (WORD_W >= ADDR_W) begin : g_ptr_slice
         assign ptr = ind_data[ADDR_W-1:0];
      end else begin : g_ptr_pad
         assign ptr = {{(ADDR_W-WORD_W){1'b0}}, ind_data};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         len_q     <= '0;
         flags_q   <= '0;
         kind_q    <= OPK_NONE;
         illegal_q <= 1'b0;
         ta_q      <= '0;
         ind_req   <= 1'b0;
         ind_addr  <= '0;
      end else begin
         done <= 1'b0;
         if (ind_req) begin
            if (ind_ack) begin
               ta_q    <= ptr;
               ind_req <= 1'b0;
               done    <= 1'b1;
            end
         end else if (start) begin
            len_q     <= len_in;
            flags_q   <= flags_in;
            kind_q    <= kind_in;
            illegal_q <= illegal_in;
            ta_q      <= ta_in;
            if ((kind_in == OPK_IND) && !illegal_in) begin
               ind_req  <= 1'b1;
               ind_addr <= ta_in;
            end else begin
               done <= 1'b1;
            end
         end
      end
   end

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req && !ind_ack |=> ind_req && $stable(ind_addr));

   // R8
   ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req && ind_ack |=> done && !ind_req && (kind_q == OPK_IND));

   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ind_req && start && !ind_ack |=> $stable(flags_q) && $stable(len_q));

   // R9
   illegal_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && illegal_q |-> !ind_req && !$past(ind_req));

endmodule

// File: rtl/xe_addr_gen.sv
module xe_addr_gen
   import xe_ag_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int WORD_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [ADDR_W-1:0]   pc,
   input  logic [WORD_W-1:0]   base_reg,
   input  logic [WORD_W-1:0]   index_reg,
   input  logic                ind_ack,
   input  logic [WORD_W-1:0]   ind_data,
   output logic                done,
   output logic [LEN_W-1:0]    len,
   output logic [FLAG_W-1:0]   flags,
   output logic [1:0]          kind,
   output logic [ADDR_W-1:0]   ta,
   output logic                illegal,
   output logic                ind_req,
   output logic [ADDR_W-1:0]   ind_addr
);

   generate
      if (ADDR_W < LONG_W) begin : g_bad_addr
         $error("xe_addr_gen: ADDR_W must hold the 20-bit long address field");
      end
      if (WORD_W < OLD_W + 1) begin : g_bad_word
         $error("xe_addr_gen: WORD_W too narrow for register operands");
      end
   endgenerate

   logic [ADDR_W-1:0] breg, xreg, ta_c;
   logic [LEN_W-1:0]  d_len;
   logic [FLAG_W-1:0] d_flags;
   opkind_e           d_kind, q_kind;
   logic              d_illegal, d_short, d_off_neg, d_idx;
   bsel_e             d_bsel;
   logic [LONG_W-1:0] d_off;

   generate
      if (WORD_W >= ADDR_W) begin : g_reg_slice
         assign breg = base_reg[ADDR_W-1:0];
         assign xreg = index_reg[ADDR_W-1:0];
      end else begin : g_reg_pad
         assign breg = {{(ADDR_W-WORD_W){1'b0}}, base_reg};
         assign xreg = {{(ADDR_W-WORD_W){1'b0}}, index_reg};
      end
   endgenerate

   xe_ag_decode u_dec (
      .instr     (instr),
      .len_o     (d_len),
      .flags_o   (d_flags),
      .kind_o    (d_kind),
      .illegal_o (d_illegal),
      .short_o   (d_short),
      .bsel_o    (d_bsel),
      .off_o     (d_off),
      .off_neg_o (d_off_neg),
      .use_idx_o (d_idx)
   );

   xe_ag_calc #(.ADDR_W(ADDR_W)) u_calc (
      .pc       (pc),
      .breg     (breg),
      .xreg     (xreg),
      .len      (d_len),
      .bsel     (d_bsel),
      .off      (d_off),
      .off_neg  (d_off_neg),
      .use_idx  (d_idx),
      .short_in (d_short),
      .ta_o     (ta_c)
   );

   xe_ag_ctl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .len_in     (d_len),
      .flags_in   (d_flags),
      .kind_in    (d_kind),
      .illegal_in (d_illegal),
      .ta_in      (ta_c),
      .ind_ack    (ind_ack),
      .ind_data   (ind_data),
      .done       (done),
      .len_q      (len),
      .flags_q    (flags),
      .kind_q     (q_kind),
      .illegal_q  (illegal),
      .ta_q       (ta),
      .ind_req    (ind_req),
      .ind_addr   (ind_addr)
   );

   assign kind = q_kind;

   // R1
   short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && (q_kind == OPK_NONE) |-> (len == 3'd1 || len == 3'd2) && (ta == '0));

endmodule

// File: tb/xe_addr_gen_test.sv
module xe_addr_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic [19:0] pc = '0;
   logic [23:0] base_reg = '0;
   logic [23:0] index_reg = '0;
   logic        ind_ack = 1'b0;
   logic [23:0] ind_data = '0;
   logic        done;
   logic [2:0]  len;
   logic [5:0]  flags;
   logic [1:0]  kind;
   logic [19:0] ta;
   logic        illegal;
   logic        ind_req;
   logic [19:0] ind_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   xe_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc(pc),
      .base_reg(base_reg), .index_reg(index_reg), .ind_ack(ind_ack),
      .ind_data(ind_data), .done(done), .len(len), .flags(flags),
      .kind(kind), .ta(ta), .illegal(illegal), .ind_req(ind_req),
      .ind_addr(ind_addr)
   );

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Table: pc=12340, B=05000, X=00100 for every row
   localparam int NV = 13;
   localparam logic [31:0] V_INS [NV] = '{
      32'hC4000000,  // R1 one byte
      32'h90450000,  // R1 two bytes
      32'h00812300,  // R2 old layout, indexed
      32'h034FFF00,  // R3 base relative, max disp
      32'h03280000,  // R4 pc relative, -2048
      32'h03A01000,  // R4 R6 pc relative + index
      32'h01012C00,  // R7 immediate, 3-byte
      32'h011ABCDE,  // R7 R5 immediate, 4-byte
      32'h039FFFFF,  // R6 R5 4-byte + index wraps
      32'h03600000,  // R9 b and p
      32'h01800500,  // R9 immediate + index
      32'h03500010,  // R9 4-byte with b
      32'h02800700   // R9 indirect + index, no request
   };
   localparam logic [2:0]  V_LEN [NV] = '{3'd1,3'd2,3'd3,3'd3,3'd3,3'd3,3'd3,3'd4,3'd4,3'd3,3'd3,3'd4,3'd3};
   localparam logic [5:0]  V_FLG [NV] = '{6'h00,6'h00,6'h08,6'h34,6'h32,6'h3A,6'h10,6'h11,6'h39,6'h36,6'h18,6'h35,6'h28};
   localparam logic [1:0]  V_KND [NV] = '{2'd0,2'd0,2'd2,2'd2,2'd2,2'd2,2'd1,2'd1,2'd2,2'd2,2'd1,2'd2,2'd3};
   localparam logic        V_ILL [NV] = '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1};
   localparam logic [19:0] V_TA  [NV] = '{20'h0,20'h0,20'h00223,20'h05FFF,20'h11B43,20'h12453,
                                          20'h0012C,20'hABCDE,20'h000FF,20'h0,20'h00105,20'h00010,20'h00107};
   string v_req [NV] = '{"R1","R1","R2","R3","R4","R6","R7","R5","R6","R9","R9","R9","R9"};

   task automatic issue(input logic [31:0] ins);
      @(negedge clk);
      instr = ins;
      start = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      start = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      // R11 reset state
      check("R11", "done", {31'b0, done}, 32'd0);
      check("R11", "ind_req", {31'b0, ind_req}, 32'd0);
      check("R11", "ta", {12'b0, ta}, 32'd0);
      check("R11", "len", {29'b0, len}, 32'd0);
      check("R11", "illegal", {31'b0, illegal}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      pc = 20'h12340;
      base_reg = 24'h005000;
      index_reg = 24'h000100;
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         instr = V_INS[k];
         start = 1'b1;
         @(posedge clk);
         #1;
         check(v_req[k], "done", {31'b0, done}, 32'd1);
         check(v_req[k], "len", {29'b0, len}, {29'b0, V_LEN[k]});
         check(v_req[k], "flags", {26'b0, flags}, {26'b0, V_FLG[k]});
         check(v_req[k], "kind", {30'b0, kind}, {30'b0, V_KND[k]});
         check(v_req[k], "illegal", {31'b0, illegal}, {31'b0, V_ILL[k]});
         check(v_req[k], "ta", {12'b0, ta}, {12'b0, V_TA[k]});
         check(v_req[k], "ind_req", {31'b0, ind_req}, 32'd0);
         @(negedge clk);
         start = 1'b0;
      end

      // R3 base-relative wrap: FFF00 + 200 -> 00100
      base_reg = 24'hAFFF00;
      @(negedge clk);
      instr = 32'h03420000;
      start = 1'b1;
      @(posedge clk);
      #1;
      check("R3", "wrap ta", {12'b0, ta}, 32'h00100);
      @(negedge clk);
      start = 1'b0;

      // R6 indexed old layout with wrap: 7FFF + FFFF1 -> 07FF0
      index_reg = 24'h0FFFF1;
      @(negedge clk);
      instr = 32'h00FFFF00;
      start = 1'b1;
      @(posedge clk);
      #1;
      check("R6", "old wrap ta", {12'b0, ta}, 32'h07FF0);
      check("R2", "old len", {29'b0, len}, 32'd3);
      @(negedge clk);
      start = 1'b0;

      // R8 R10 indirect via base: B=05000 + 010
      base_reg = 24'h005000;
      index_reg = 24'h000100;
      @(negedge clk);
      instr = 32'h02401000;
      start = 1'b1;
      @(posedge clk);
      #1;
      check("R8", "req raised", {31'b0, ind_req}, 32'd1);
      check("R8", "req addr", {12'b0, ind_addr}, 32'h05010);
      check("R8", "no done yet", {31'b0, done}, 32'd0);
      @(negedge clk);
      instr = 32'hC4000000;
      start = 1'b1;
      for (int w = 0; w < 3; w++) begin
         @(posedge clk);
         #1;
         check("R10", "req held", {31'b0, ind_req}, 32'd1);
         check("R10", "addr held", {12'b0, ind_addr}, 32'h05010);
         check("R10", "flags held", {26'b0, flags}, 32'h24);
         check("R10", "len held", {29'b0, len}, 32'd3);
         check("R10", "no done", {31'b0, done}, 32'd0);
      end
      @(negedge clk);
      start = 1'b0;
      ind_ack = 1'b1;
      ind_data = 24'h7ABCDE;
      @(posedge clk);
      #1;
      check("R8", "done after ack", {31'b0, done}, 32'd1);
      check("R8", "ptr ta", {12'b0, ta}, 32'hABCDE);
      check("R8", "kind ind", {30'b0, kind}, 32'd3);
      check("R8", "req dropped", {31'b0, ind_req}, 32'd0);
      @(negedge clk);
      ind_ack = 1'b0;
      @(posedge clk);
      #1;
      check("R8", "done single", {31'b0, done}, 32'd0);

      // R7 simple mode (n=i=1) is memory kind, issued after indirect
      issue(32'h03000500);
      check("R7", "simple kind", {30'b0, kind}, 32'd2);
      check("R5", "direct ta", {12'b0, ta}, 32'h00005);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule